// File: doc/BRIEF.md
# Cable Receiver Control Arbiter

This block is the control logic of an adaptive cable receiver. A single mode input chooses whether the receiver is steered by strapped pins or by register fields that a serial register block supplies. The block decodes the four multi-function pins according to that choice and settles the order among sleep, mute and bypass requests. From a signal-present flag, a 9-bit cable-length estimate and the detected rate, it produces the power-down, mute, equalizer-bypass and retimer-bypass controls, plus one enable for each output driver.

The block also forms an active-low signal-detect flag. In hardware mode, and in software mode with the digital threshold off, that flag uses an externally supplied analog over-length comparison. With the digital threshold selected, it compares the length estimate against a limit derived from a 5-bit code. The flag is steered onto the multi-function pin that the active mode assigns to it. All outputs are registered once per clock.

Top module: `eqctl_arbiter`

## Requirements
- R1: With `mode_sw`=0, `mf_oe`=4'b1000 and `mf_out[3]` carries the detect flag, with all other `mf_out` bits 0. With `mode_sw`=1, `mf_oe`=4'b0011, `mf_out[0]` carries the detect flag and `mf_out[1]` carries `ser_so`. `ser_sck`=`mf_lvl[2]` and `ser_si`=`mf_lvl[3]` in software mode, and both are 0 in hardware mode.
- R2: In hardware mode the bypass pin is `{mf0_drv, mf_lvl[0]}`. Driven high bypasses both the equalizer and the retimer. Floating (`mf0_drv`=0) bypasses only the retimer. Driven low requests no bypass.
- R3: In hardware mode, `mf_lvl[1]`=1 powers the receiver down while `sig_present`=0, and `mf_lvl[2]`=1 mutes.
- R4: In software mode `cfg_sleep` selects the power behaviour: 2'b00 is never power down, 2'b01 is power down while `sig_present`=0, 2'b10 is always power down, and the reserved 2'b11 behaves like 2'b00.
- R5: Sleep outranks mute and mute outranks bypass. While `pwr_dn`=1, `mute_o`, `eq_byp_o` and `jc_byp_o` are 0. While `mute_o`=1, both bypass outputs are 0.
- R6: `sd_n`=1 when `sig_present`=0 or the length is over the limit. The analog comparison `ana_over` is used unless `mode_sw`=1 and `cfg_thr_dig`=1.
- R7: The digital limit for code c is the length index for (10 + 9.5·c) metres. The index is metres/0.625 up to 250 m, and above that it is 400 + (metres−250)/2.5, truncated. Over-length means the index is strictly greater than the limit. Code 5'b11111 never reports over-length.
- R8: `rate_det` uses 00=SD, 01=HD, 10=3G and 11=undetermined. The retimer is bypassed for SD, undetermined, an equalizer bypass or a retimer-bypass request (subject to R5). `rate_stat` is 00 for SD, 11 when the retimer is bypassed for any other rate, and otherwise equals `rate_det`.
- R9: Driver i is enabled when not powered down and, in software mode, its 2-bit swing field `cfg_swing[2i+1:2i]` is not 00. Hardware mode ignores the swing fields. `sdo1_dis`=1 forces driver 1 off in both modes.
- R10: Every output changes one clock after its inputs. During reset, `pwr_dn`=1, `sd_n`=1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sw | input | 1 | 0 selects pin control, 1 selects register control |
| mf_lvl | input | 4 | Sensed levels of the multi-function pins |
| mf0_drv | input | 1 | 1 when pin 0 is driven, 0 when it floats |
| sdo1_dis | input | 1 | Forces the second output driver off |
| sig_present | input | 1 | Input signal detected |
| cable_len | input | 9 | Cable-length index from the equalizer |
| ana_over | input | 1 | Analog over-length comparison |
| rate_det | input | 2 | Rate detector status |
| cfg_sleep | input | 2 | Register sleep mode |
| cfg_mute | input | 1 | Register mute |
| cfg_eq_byp | input | 1 | Register equalizer bypass |
| cfg_jc_byp | input | 1 | Register retimer bypass |
| cfg_thr_dig | input | 1 | Selects the digital length threshold |
| cfg_thr_code | input | 5 | Digital threshold code |
| cfg_swing | input | 4 | Swing field per output driver |
| ser_so | input | 1 | Serial data out from the register block |
| pwr_dn | output | 1 | Receiver power-down |
| mute_o | output | 1 | Output mute |
| eq_byp_o | output | 1 | Equalizer bypass |
| jc_byp_o | output | 1 | Retimer bypass and power-off |
| drv_en | output | 2 | Output driver enables |
| sd_n | output | 1 | Active-low signal detect |
| rate_stat | output | 2 | Reported rate status |
| mf_oe | output | 4 | Multi-function pin output enables |
| mf_out | output | 4 | Multi-function pin output values |
| ser_sck | output | 1 | Serial clock to the register block |
| ser_si | output | 1 | Serial data in to the register block |

## Verification
The assertions assume that every input is a settled, synchronous level at each rising edge. Pin levels and register fields are therefore taken to be already synchronized, and no pin is taken to change between samples in a way the block must filter. The bench changes inputs only on falling edges, so each value is stable across the next rising edge. It mixes directed cases (threshold boundaries, reserved sleep code, floating bypass pin) with unconstrained random values, since every property must hold for any input combination.

// File: rtl/eqctl_pkg.sv
package eqctl_pkg;

  localparam int LEN_W_DEF  = 9;
  localparam int CODE_W_DEF = 5;
  localparam int SW_W_DEF   = 2;
  localparam int N_DRV_DEF  = 2;

  // pin roles, hardware mode
  localparam int MF_BYP    = 0;
  localparam int MF_SLP    = 1;
  localparam int MF_MUTE   = 2;
  localparam int MF_SD_HW  = 3;
  // pin roles, software mode
  localparam int MF_SD_SW  = 0;
  localparam int MF_SO     = 1;
  localparam int MF_SCK    = 2;
  localparam int MF_SI     = 3;

  localparam logic [3:0] OE_HW = 4'b1000;
  localparam logic [3:0] OE_SW = 4'b0011;

  // sleep field
  localparam logic [1:0] SLP_ON   = 2'b00;
  localparam logic [1:0] SLP_AUTO = 2'b01;
  localparam logic [1:0] SLP_OFF  = 2'b10;

  // rate codes
  localparam logic [1:0] RATE_SD  = 2'b00;
  localparam logic [1:0] RATE_UNK = 2'b11;

  // threshold law in half metres
  localparam int THR_BASE_HM = 20;
  localparam int THR_STEP_HM = 19;
  localparam int KNEE_HM     = 500;
  localparam int KNEE_IDX    = 400;

  typedef struct packed {
    logic sleep;
    logic mute;
    logic eq_byp;
    logic jc_byp;
  } ctl_req_t;

  // length index limit for a threshold code
  function automatic int code_to_len(int code);
    int hm;
    hm = THR_BASE_HM + THR_STEP_HM * code;
    if (hm <= KNEE_HM) return (hm * 4) / 5;
    return KNEE_IDX + (hm - KNEE_HM) / 5;
  endfunction

endpackage

// File: rtl/eqctl_mfdec.sv
module eqctl_mfdec
  import eqctl_pkg::*;
(
  input  logic       mode_sw,
  input  logic [3:0] mf_lvl,
  input  logic       mf0_drv,
  input  logic       sig_present,
  input  logic [1:0] cfg_sleep,
  input  logic       cfg_mute,
  input  logic       cfg_eq_byp,
  input  logic       cfg_jc_byp,
  input  logic       cfg_thr_dig,
  output ctl_req_t   req,
  output logic       use_dig,
  output logic       ser_sck_c,
  output logic       ser_si_c
);

  logic hw_pin_high;
  logic hw_pin_float;

  assign hw_pin_high  = mf0_drv && mf_lvl[MF_BYP];
  assign hw_pin_float = !mf0_drv;

  always_comb begin
    if (!mode_sw) begin
      req.sleep  = mf_lvl[MF_SLP] && !sig_present;
      req.mute   = mf_lvl[MF_MUTE];
      req.eq_byp = hw_pin_high;
      req.jc_byp = hw_pin_high || hw_pin_float;
    end else begin
      unique case (cfg_sleep)
        SLP_AUTO: req.sleep = !sig_present;
        SLP_OFF:  req.sleep = 1'b1;
        default:  req.sleep = 1'b0;
      endcase
      req.mute   = cfg_mute;
      req.eq_byp = cfg_eq_byp;
      req.jc_byp = cfg_jc_byp;
    end
  end

  assign use_dig   = mode_sw && cfg_thr_dig;
  assign ser_sck_c = mode_sw && mf_lvl[MF_SCK];
  assign ser_si_c  = mode_sw && mf_lvl[MF_SI];

endmodule

// File: rtl/eqctl_sigdet.sv
module eqctl_sigdet
  import eqctl_pkg::*;
#(
  parameter int LEN_W  = LEN_W_DEF,
  parameter int CODE_W = CODE_W_DEF
) (
  input  logic              sig_present,
  input  logic [LEN_W-1:0]  cable_len,
  input  logic              ana_over,
  input  logic              use_dig,
  input  logic [CODE_W-1:0] thr_code,
  output logic              len_over,
  output logic              sd_n_c
);

  localparam logic [CODE_W-1:0] NEVER_CODE = {CODE_W{1'b1}};

  logic [LEN_W-1:0] len_lim;
  logic             dig_over;

  assign len_lim  = LEN_W'(code_to_len(int'(thr_code)));
  assign dig_over = (thr_code != NEVER_CODE) && (cable_len > len_lim);
  assign len_over = use_dig ? dig_over : ana_over;
  assign sd_n_c   = !sig_present || len_over;

endmodule

// File: rtl/eqctl_prio.sv
module eqctl_prio
  import eqctl_pkg::*;
#(
  parameter int N_DRV = N_DRV_DEF,
  parameter int SW_W  = SW_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_sw,
  input  ctl_req_t              req,
  input  logic [1:0]            rate_det,
  input  logic [N_DRV*SW_W-1:0] cfg_swing,
  input  logic                  sdo1_dis,
  input  logic                  sd_n_c,
  input  logic                  ser_so,
  input  logic                  ser_sck_c,
  input  logic                  ser_si_c,
  output logic                  pwr_dn,
  output logic                  mute_o,
  output logic                  eq_byp_o,
  output logic                  jc_byp_o,
  output logic [N_DRV-1:0]      drv_en,
  output logic                  sd_n,
  output logic [1:0]            rate_stat,
  output logic [3:0]            mf_oe,
  output logic [3:0]            mf_out,
  output logic                  ser_sck,
  output logic                  ser_si
);

  localparam int DIS_IDX = 1;

  logic             pass_n;
  logic             rate_auto;
  logic             mute_n, eqb_n, jcb_n;
  logic [1:0]       rate_n;
  logic [N_DRV-1:0] drv_n;
  logic [3:0]       oe_n, out_n;

  assign pass_n    = !req.sleep && !req.mute;
  assign rate_auto = (rate_det == RATE_SD) || (rate_det == RATE_UNK);
  assign mute_n    = !req.sleep && req.mute;
  assign eqb_n     = pass_n && req.eq_byp;
  assign jcb_n     = pass_n && (req.jc_byp || req.eq_byp || rate_auto);
  assign rate_n    = (rate_det == RATE_SD) ? RATE_SD :
                     (jcb_n ? RATE_UNK : rate_det);

  for (genvar i = 0; i < N_DRV; i++) begin : g_drv
    logic swing_on;
    assign swing_on = |cfg_swing[i*SW_W +: SW_W];
    if (i == DIS_IDX) begin : g_dis
      assign drv_n[i] = !req.sleep && !sdo1_dis && (!mode_sw || swing_on);
    end else begin : g_plain
      assign drv_n[i] = !req.sleep && (!mode_sw || swing_on);
    end
  end

  always_comb begin
    out_n = '0;
    if (mode_sw) begin
      oe_n            = OE_SW;
      out_n[MF_SD_SW] = sd_n_c;
      out_n[MF_SO]    = ser_so;
    end else begin
      oe_n            = OE_HW;
      out_n[MF_SD_HW] = sd_n_c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_dn    <= 1'b1;
      mute_o    <= 1'b0;
      eq_byp_o  <= 1'b0;
      jc_byp_o  <= 1'b0;
      drv_en    <= '0;
      sd_n      <= 1'b1;
      rate_stat <= RATE_SD;
      mf_oe     <= '0;
      mf_out    <= '0;
      ser_sck   <= 1'b0;
      ser_si    <= 1'b0;
    end else begin
      pwr_dn    <= req.sleep;
      mute_o    <= mute_n;
      eq_byp_o  <= eqb_n;
      jc_byp_o  <= jcb_n;
      drv_en    <= drv_n;
      sd_n      <= sd_n_c;
      rate_stat <= rate_n;
      mf_oe     <= oe_n;
      mf_out    <= out_n;
      ser_sck   <= ser_sck_c;
      ser_si    <= ser_si_c;
    end
  end

  p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!mute_o && !eq_byp_o && !jc_byp_o));

  p_mute_over_byp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o |-> (!eq_byp_o && !jc_byp_o));

  p_eqbyp_takes_jc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eq_byp_o |-> jc_byp_o);

  p_sd_rate_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_det == RATE_SD) |=> (rate_stat == RATE_SD));

  p_sdo1_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo1_dis |=> !drv_en[DIS_IDX]);

  p_oe_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_oe == 4'b0000) || (mf_oe == OE_HW) || (mf_oe == OE_SW));

endmodule

// File: rtl/eqctl_arbiter.sv
module eqctl_arbiter
  import eqctl_pkg::*;
#(
  parameter int LEN_W  = LEN_W_DEF,
  parameter int CODE_W = CODE_W_DEF,
  parameter int N_DRV  = N_DRV_DEF,
  parameter int SW_W   = SW_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_sw,
  input  logic [3:0]            mf_lvl,
  input  logic                  mf0_drv,
  input  logic                  sdo1_dis,
  input  logic                  sig_present,
  input  logic [LEN_W-1:0]      cable_len,
  input  logic                  ana_over,
  input  logic [1:0]            rate_det,
  input  logic [1:0]            cfg_sleep,
  input  logic                  cfg_mute,
  input  logic                  cfg_eq_byp,
  input  logic                  cfg_jc_byp,
  input  logic                  cfg_thr_dig,
  input  logic [CODE_W-1:0]     cfg_thr_code,
  input  logic [N_DRV*SW_W-1:0] cfg_swing,
  input  logic                  ser_so,
  output logic                  pwr_dn,
  output logic                  mute_o,
  output logic                  eq_byp_o,
  output logic                  jc_byp_o,
  output logic [N_DRV-1:0]      drv_en,
  output logic                  sd_n,
  output logic [1:0]            rate_stat,
  output logic [3:0]            mf_oe,
  output logic [3:0]            mf_out,
  output logic                  ser_sck,
  output logic                  ser_si
);

  ctl_req_t req;
  logic     use_dig;
  logic     ser_sck_c, ser_si_c;
  logic     len_over, sd_n_c;

  eqctl_mfdec u_mfdec (
    .mode_sw     (mode_sw),
    .mf_lvl      (mf_lvl),
    .mf0_drv     (mf0_drv),
    .sig_present (sig_present),
    .cfg_sleep   (cfg_sleep),
    .cfg_mute    (cfg_mute),
    .cfg_eq_byp  (cfg_eq_byp),
    .cfg_jc_byp  (cfg_jc_byp),
    .cfg_thr_dig (cfg_thr_dig),
    .req         (req),
    .use_dig     (use_dig),
    .ser_sck_c   (ser_sck_c),
    .ser_si_c    (ser_si_c)
  );

  eqctl_sigdet #(.LEN_W(LEN_W), .CODE_W(CODE_W)) u_sigdet (
    .sig_present (sig_present),
    .cable_len   (cable_len),
    .ana_over    (ana_over),
    .use_dig     (use_dig),
    .thr_code    (cfg_thr_code),
    .len_over    (len_over),
    .sd_n_c      (sd_n_c)
  );

  eqctl_prio #(.N_DRV(N_DRV), .SW_W(SW_W)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sw   (mode_sw),
    .req       (req),
    .rate_det  (rate_det),
    .cfg_swing (cfg_swing),
    .sdo1_dis  (sdo1_dis),
    .sd_n_c    (sd_n_c),
    .ser_so    (ser_so),
    .ser_sck_c (ser_sck_c),
    .ser_si_c  (ser_si_c),
    .pwr_dn    (pwr_dn),
    .mute_o    (mute_o),
    .eq_byp_o  (eq_byp_o),
    .jc_byp_o  (jc_byp_o),
    .drv_en    (drv_en),
    .sd_n      (sd_n),
    .rate_stat (rate_stat),
    .mf_oe     (mf_oe),
    .mf_out    (mf_out),
    .ser_sck   (ser_sck),
    .ser_si    (ser_si)
  );

  p_nosig_sdn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_present |=> sd_n);

  p_force_pd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sw && cfg_sleep == SLP_OFF) |=> pwr_dn);

  p_never_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_dig && (&cfg_thr_code) && sig_present) |=> !sd_n);

  p_hw_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sw && mf_lvl[MF_MUTE] && !(mf_lvl[MF_SLP] && !sig_present))
      |=> mute_o);

  p_over_only_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_present && !len_over) |=> !sd_n);

endmodule

// File: tb/eqctl_arbiter_test.sv
module eqctl_arbiter_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       mode_sw;
  logic [3:0] mf_lvl;
  logic       mf0_drv, sdo1_dis, sig_present, ana_over;
  logic [8:0] cable_len;
  logic [1:0] rate_det, cfg_sleep;
  logic       cfg_mute, cfg_eq_byp, cfg_jc_byp, cfg_thr_dig;
  logic [4:0] cfg_thr_code;
  logic [3:0] cfg_swing;
  logic       ser_so;
  logic       pwr_dn, mute_o, eq_byp_o, jc_byp_o, sd_n, ser_sck, ser_si;
  logic [1:0] drv_en, rate_stat;
  logic [3:0] mf_oe, mf_out;

  eqctl_arbiter uut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string ph = "R10";

  int e_pd, e_mu, e_eqb, e_jcb, e_drv, e_sdn, e_rate, e_oe, e_out, e_sck, e_si;

  // limit in length-index units, computed in millimetres
  function automatic int lim_idx(int code);
    int mm;
    mm = 10000 + 9500 * code;
    if (mm <= 250000) return (mm * 16) / 10000;
    return 400 + (mm - 250000) / 2500;
  endfunction

  task automatic chk(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, ph, name, act, exp);
    end
  endtask

  task automatic model();
    int sl, mu, eb, jb, over, auto_r;
    if (!mode_sw) begin
      sl = (mf_lvl[1] && !sig_present);
      mu = mf_lvl[2];
      eb = (mf0_drv && mf_lvl[0]);
      jb = (!mf0_drv || mf_lvl[0]);
    end else begin
      if (cfg_sleep == 2'd1) sl = !sig_present;
      else if (cfg_sleep == 2'd2) sl = 1;
      else sl = 0;
      mu = cfg_mute; eb = cfg_eq_byp; jb = cfg_jc_byp;
    end
    auto_r = (rate_det == 0 || rate_det == 3);
    e_pd  = sl;
    e_mu  = (!sl && mu);
    e_eqb = (!sl && !mu && eb);
    e_jcb = (!sl && !mu && (jb || eb || auto_r));
    e_rate = (rate_det == 0) ? 0 : (e_jcb ? 3 : int'(rate_det));
    if (mode_sw && cfg_thr_dig)
      over = (cfg_thr_code == 31) ? 0 : (int'(cable_len) > lim_idx(int'(cfg_thr_code)));
    else over = ana_over;
    e_sdn = (!sig_present || over);
    e_drv = 0;
    if (!sl && (!mode_sw || cfg_swing[1:0] != 0)) e_drv += 1;
    if (!sl && !sdo1_dis && (!mode_sw || cfg_swing[3:2] != 0)) e_drv += 2;
    e_oe  = mode_sw ? 3 : 8;
    e_out = mode_sw ? (e_sdn + 2 * ser_so) : 8 * e_sdn;
    e_sck = mode_sw && mf_lvl[2];
    e_si  = mode_sw && mf_lvl[3];
  endtask

  task automatic compare();
    chk("R4", "pwr_dn", pwr_dn, e_pd);
    chk("R5", "mute_o", mute_o, e_mu);
    chk("R2", "eq_byp_o", eq_byp_o, e_eqb);
    chk("R8", "jc_byp_o", jc_byp_o, e_jcb);
    chk("R9", "drv_en", drv_en, e_drv);
    chk("R6", "sd_n", sd_n, e_sdn);
    chk("R8", "rate_stat", rate_stat, e_rate);
    chk("R1", "mf_oe", mf_oe, e_oe);
    chk("R1", "mf_out", mf_out, e_out);
    chk("R1", "ser_sck", ser_sck, e_sck);
    chk("R1", "ser_si", ser_si, e_si);
  endtask

  // inputs were set at a falling edge; outputs checked one clock later (R10)
  task automatic cyc();
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic base();
    mode_sw = 0; mf_lvl = 4'b0000; mf0_drv = 1; sdo1_dis = 0;
    sig_present = 1; ana_over = 0; cable_len = 9'd100; rate_det = 2'd1;
    cfg_sleep = 2'd0; cfg_mute = 0; cfg_eq_byp = 0; cfg_jc_byp = 0;
    cfg_thr_dig = 0; cfg_thr_code = 5'd20; cfg_swing = 4'b1010; ser_so = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    base();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    ph = "R10";
    chk("R10", "rst pwr_dn", pwr_dn, 1);
    chk("R10", "rst sd_n", sd_n, 1);
    chk("R10", "rst mute", mute_o, 0);
    chk("R10", "rst bypass", eq_byp_o + jc_byp_o, 0);
    chk("R10", "rst drv_en", drv_en, 0);
    chk("R10", "rst mf_oe", mf_oe, 0);
    chk("R10", "rst mf_out", mf_out, 0);
    chk("R10", "rst rate", rate_stat, 0);
    rst_n = 1;
    cyc();

    // R2 three-level bypass pin
    ph = "R2";
    mf0_drv = 1; mf_lvl[0] = 0; cyc();
    mf0_drv = 1; mf_lvl[0] = 1; cyc();
    mf0_drv = 0; mf_lvl[0] = 0; cyc();
    mf0_drv = 0; mf_lvl[0] = 1; cyc();
    mf0_drv = 1; mf_lvl[0] = 0;

    // R3 auto-sleep and mute pins
    ph = "R3";
    mf_lvl[1] = 1; sig_present = 1; cyc();
    sig_present = 0; cyc();
    mf_lvl[1] = 0; cyc();
    mf_lvl[2] = 1; sig_present = 1; cyc();
    mf_lvl = 4'b0000;

    // R4 software sleep codes, R1 software pin map
    ph = "R4";
    mode_sw = 1; ser_so = 1; mf_lvl = 4'b1100;
    for (int s = 0; s < 4; s++) begin
      cfg_sleep = 2'(s);
      sig_present = 1; cyc();
      sig_present = 0; cyc();
    end
    cfg_sleep = 0; sig_present = 1;

    // R5 precedence
    ph = "R5";
    cfg_mute = 1; cfg_eq_byp = 1; cfg_jc_byp = 1; cyc();
    cfg_sleep = 2'd2; cyc();
    cfg_sleep = 0; cfg_mute = 0; cyc();
    cfg_eq_byp = 0; cfg_jc_byp = 0;

    // R7 digital threshold boundaries, R6 source select
    ph = "R7";
    cfg_thr_dig = 1; ana_over = 1;
    cfg_thr_code = 5'd20; cable_len = 9'd320; cyc();
    cable_len = 9'd321; cyc();
    cfg_thr_code = 5'd0; cable_len = 9'd16; cyc();
    cable_len = 9'd17; cyc();
    cfg_thr_code = 5'd30; cable_len = 9'd418; cyc();
    cable_len = 9'd419; cyc();
    cfg_thr_code = 5'd31; cable_len = 9'd511; cyc();
    ph = "R6";
    cfg_thr_dig = 0; cyc();
    ana_over = 0; cyc();
    mode_sw = 0; cfg_thr_dig = 1; ana_over = 1; cable_len = 0; cyc();
    ana_over = 0; mode_sw = 1;

    // R8 rate auto-bypass and status
    ph = "R8";
    for (int r = 0; r < 4; r++) begin
      rate_det = 2'(r); cyc();
    end
    cfg_jc_byp = 1; rate_det = 2'd2; cyc();
    cfg_jc_byp = 0;

    // R9 drivers
    ph = "R9";
    cfg_swing = 4'b0000; cyc();
    cfg_swing = 4'b0100; cyc();
    sdo1_dis = 1; cyc();
    mode_sw = 0; cyc();
    sdo1_dis = 0; cyc();

    // mixed random traffic across all requirements
    ph = "R1 R6 R7 R9";
    for (int k = 0; k < 3000; k++) begin
      mode_sw = 1'($urandom); mf_lvl = 4'($urandom); mf0_drv = 1'($urandom);
      sdo1_dis = 1'($urandom); sig_present = 1'($urandom); ana_over = 1'($urandom);
      cable_len = 9'($urandom); rate_det = 2'($urandom); cfg_sleep = 2'($urandom);
      cfg_mute = 1'($urandom); cfg_eq_byp = 1'($urandom); cfg_jc_byp = 1'($urandom);
      cfg_thr_dig = 1'($urandom); cfg_thr_code = 5'($urandom);
      cfg_swing = 4'($urandom); ser_so = 1'($urandom);
      if (k % 4 == 0) cable_len = 9'(lim_idx(int'(cfg_thr_code)) + int'($urandom % 2));
      cyc();
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule